// File: doc/BRIEF.md
# Dual-Register Capture/Compare Timer Channel

This block is one timer channel that watches a shared free-running counter bus and drives or samples a single I/O signal. A 3-bit mode field selects whether the channel is idle, measures an input (edge time, period, or pulse width), or drives an output (single compare, double compare, or PWM). The channel keeps two data registers, A and B. Register B is backed by two latches: a buffer latch B1 and an active latch B2. The mode decides which latch a bus read of B returns and which latches a bus write of B updates.

Software reaches the channel through a small synchronous register port. It can read and write A, B and a control/status word. The control/status word appears at two adjacent addresses with identical effect, so that a 32-bit access can fetch it together with its neighbour. In input modes, a bus read of A or B that lands in the same cycle as a capture into those registers pushes the capture back by one cycle. This keeps the value returned to software coherent.

Top module: `cc_timer_channel`

## Requirements
- R1: After reset, A, B1, B2 and the control word read as zero, the mode is 0 (disabled), `pin_out` is low and `cap_flag` is low.
- R2: Address 0 is A, address 1 is B, and addresses 2 and 3 are both the control/status word with identical read and write effect. Control word bits [2:0] hold the mode (0 disabled, 1 pulse-width input, 2 period input, 3 edge-capture input, 4 single compare, 5 double compare, 6 PWM output, 7 behaves as disabled). Bit 3 is edge polarity (0 selects rising, 1 selects falling). Bit 15 is a read-only status bit. Reads appear on `bus_rdata` one clock after `bus_re`.
- R3: In disabled mode, a write of B updates both B1 and B2, and a read of B returns B1.
- R4: In PWM output mode, a write of B updates B1 only and a read of B returns B1. B2 keeps its value, which becomes visible once an input mode is selected.
- R5: In edge-capture mode, each selected edge of the synchronized pin copies the counter into A and the old A into B2, and pulses `cap_flag`. The pin passes through two synchronizer flops. The counter value captured is the one on `cnt_bus` in the clock cycle after the second flop has taken the new level.
- R6: In period mode, captures work as in R5, but `cap_flag` pulses only from the second selected edge after the control word was written.
- R7: In pulse-width mode, the leading edge (the selected polarity) copies the counter into B1. The trailing edge copies the counter into A and B1 into B2, and pulses `cap_flag`. In all input modes a read of B returns B2.
- R8: In input modes, when a read of A or B occurs in the cycle a capture would happen, the capture happens one cycle later with that later counter value, and the read returns the old value.
- R9: In double compare mode, writing A arms the A comparator and writing B arms the B comparator. An armed A match sets `pin_out` and an armed B match clears it. Each comparator disarms after its match, and a clear wins over a set in the same cycle.
- R10: In single compare mode, only the B comparator works. It is armed by a write of B, it toggles `pin_out` on a match, and it then disarms.
- R11: In PWM output mode, every match of A sets `pin_out` and copies B1 into B2. Every match of B2 clears `pin_out`, so a B write takes effect only from the next period. A clear wins over a set in the same cycle.
- R12: The status bit shows the synchronized pin level in input modes and the `pin_out` flip-flop in all other modes.
- R13: Any write of the control word disarms both comparators, and selecting mode 0 drives `pin_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_bus | input | 16 | Shared counter value |
| pin_in | input | 1 | Asynchronous channel input signal |
| pin_out | output | 1 | Registered channel output signal |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cap_flag | output | 1 | One-cycle pulse when a measurement completes |

## Verification
Several checks run on every cycle. The assertions check that `pin_out` is low right after reset. They check that a disabled-mode write of B leaves both latches equal, that a PWM-mode write leaves B2 untouched unless a period starts, and that a colliding read always defers a pending capture. They also check that compare comparators disarm after a match and that a PWM clear wins over a set. The remaining behaviours can only be shown by the bench's scenarios: exact captured counter values and their latency, which latch a read of B reveals after a mode change, the one-shot behaviour seen over a second counter lap, the deferred PWM duty update, and the flag timing of period mode.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_PWIN   = 3'd1,
    M_PERIN  = 3'd2,
    M_EDGEIN = 3'd3,
    M_CMPB   = 3'd4,
    M_CMPAB  = 3'd5,
    M_PWMOUT = 3'd6,
    M_SPARE  = 3'd7
  } chan_mode_e;

  typedef enum logic [1:0] {
    ADR_A    = 2'd0,
    ADR_B    = 2'd1,
    ADR_CTL  = 2'd2,
    ADR_CTLD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } cap_evt_t;

  function automatic logic is_input(chan_mode_e m);
    return (m == M_PWIN) || (m == M_PERIN) || (m == M_EDGEIN);
  endfunction

  function automatic logic b_reads_b1(chan_mode_e m);
    return (m == M_OFF) || (m == M_SPARE) || (m == M_PWMOUT);
  endfunction
endpackage

// File: rtl/cc_pin_sync.sv
module cc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign pin_s = chain_q[STAGES-1];
  assign rise  = pin_s & ~prev_q;
  assign fall  = ~pin_s & prev_q;
endmodule

// File: rtl/cc_capture_ctl.sv
module cc_capture_ctl
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  chan_mode_e mode,
  input  logic       pol,
  input  logic       rise,
  input  logic       fall,
  input  logic       rd_hit,
  input  logic       ctl_wr,
  output cap_evt_t   evt,
  output logic       flag_q
);
  cap_evt_t cur;
  cap_evt_t pend_q;
  logic     pend_v;
  logic     seen_q;
  logic     sel_edge, oth_edge, flag_d;

  assign sel_edge = pol ? fall : rise;
  assign oth_edge = pol ? rise : fall;

  always_comb begin
    cur.lead  = is_input(mode) && sel_edge;
    cur.trail = (mode == M_PWIN) && oth_edge;
  end

  // A pending event always runs; a fresh event colliding with a read waits.
  always_comb begin
    if (pend_v)                evt = pend_q;
    else if (rd_hit && (|cur)) evt = '0;
    else                       evt = cur;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_wr) begin
      pend_v <= 1'b0;
      pend_q <= '0;
    end else if (pend_v) begin
      pend_v <= |cur;
      pend_q <= cur;
    end else if (rd_hit && (|cur)) begin
      pend_v <= 1'b1;
      pend_q <= cur;
    end
  end

  always_comb begin
    unique case (mode)
      M_PWIN:   flag_d = evt.trail;
      M_EDGEIN: flag_d = evt.lead;
      M_PERIN:  flag_d = evt.lead && seen_q;
      default:  flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_wr) begin
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mode == M_PERIN && evt.lead) seen_q <= 1'b1;
      flag_q <= flag_d;
    end
  end

  AST_READ_DEFERS: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !pend_v && (|cur) && !ctl_wr) |=> pend_v) else $error("defer"); // R8
endmodule

// File: rtl/cc_data_regs.sv
module cc_data_regs
  import cc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic          ctl_wr,
  input  cap_evt_t      evt,
  input  logic          a_hit,
  input  logic          pin_s,
  input  logic          out_q,
  output logic [CW-1:0] a_q,
  output logic [CW-1:0] b2_q,
  output chan_mode_e    mode_q,
  output logic          pol_q,
  output logic [CW-1:0] rdata_q
);
  localparam int STAT_BIT = CW - 1;
  localparam int FLD_W    = 4;

  logic [CW-1:0] b1_q;
  logic [CW-1:0] ctl_word, b_view;
  logic          stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_OFF;
      pol_q  <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= chan_mode_e'(wdata[2:0]);
      pol_q  <= wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
    end else if ((evt.lead && (mode_q == M_PERIN || mode_q == M_EDGEIN)) || evt.trail) begin
      a_q <= cnt;
    end else if (a_wr) begin
      a_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b1_q <= '0;
    end else if (evt.lead && mode_q == M_PWIN) begin
      b1_q <= cnt;
    end else if (b_wr) begin
      b1_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b2_q <= '0;
    end else if (evt.lead && (mode_q == M_PERIN || mode_q == M_EDGEIN)) begin
      b2_q <= a_q;
    end else if (evt.trail || (mode_q == M_PWMOUT && a_hit)) begin
      b2_q <= b1_q;
    end else if (b_wr && mode_q != M_PWMOUT) begin
      b2_q <= wdata;
    end
  end

  assign stat   = is_input(mode_q) ? pin_s : out_q;
  assign b_view = b_reads_b1(mode_q) ? b1_q : b2_q;

  always_comb begin
    ctl_word           = '0;
    ctl_word[2:0]      = mode_q;
    ctl_word[FLD_W-1]  = pol_q;
    ctl_word[STAT_BIT] = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (reg_sel_e'(addr))
        ADR_A:   rdata_q <= a_q;
        ADR_B:   rdata_q <= b_view;
        default: rdata_q <= ctl_word;
      endcase
    end
  end

  AST_DIS_B_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OFF && b_wr) |=> (b1_q == b2_q)) else $error("mirror"); // R3
  AST_PWM_B2_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PWMOUT && b_wr && !a_hit) |=> $stable(b2_q)) else $error("b2 hold"); // R4
endmodule

// File: rtl/cc_compare_out.sv
module cc_compare_out
  import cc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  chan_mode_e    mode,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] a_q,
  input  logic [CW-1:0] b2_q,
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic          ctl_wr,
  input  logic          ctl_off,
  output logic          a_hit,
  output logic          b_hit,
  output logic          out_q
);
  logic a_arm_q, b_arm_q;
  logic a_eq, b_eq;

  assign a_eq = (cnt == a_q);
  assign b_eq = (cnt == b2_q);

  always_comb begin
    a_hit = 1'b0;
    b_hit = 1'b0;
    unique case (mode)
      M_CMPB:   b_hit = b_eq && b_arm_q;
      M_CMPAB: begin
        a_hit = a_eq && a_arm_q;
        b_hit = b_eq && b_arm_q;
      end
      M_PWMOUT: begin
        a_hit = a_eq;
        b_hit = b_eq;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_wr) begin
      a_arm_q <= 1'b0;
      b_arm_q <= 1'b0;
    end else begin
      if (a_wr && mode == M_CMPAB)                      a_arm_q <= 1'b1;
      else if (a_hit)                                   a_arm_q <= 1'b0;
      if (b_wr && (mode == M_CMPB || mode == M_CMPAB))  b_arm_q <= 1'b1;
      else if (b_hit)                                   b_arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_off) begin
      out_q <= 1'b0;
    end else begin
      unique case (mode)
        M_CMPB: if (b_hit) out_q <= ~out_q;
        M_CMPAB, M_PWMOUT: begin
          if (b_hit)      out_q <= 1'b0;
          else if (a_hit) out_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_OUT_LOW_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_q) else $error("reset out"); // R1
  AST_ONESHOT_B: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_CMPB || mode == M_CMPAB) && b_hit && !b_wr && !ctl_wr) |=> !b_arm_q) else $error("oneshot"); // R9
  AST_PWM_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PWMOUT && b_hit && !ctl_off) |=> !out_q) else $error("pwm clear"); // R11
endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel
  import cc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_bus,
  input  logic          pin_in,
  output logic          pin_out,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          cap_flag
);
  logic          pin_s, rise, fall;
  logic          a_wr, b_wr, ctl_wr, ctl_off, rd_hit;
  logic          a_hit, b_hit, out_q;
  logic [CW-1:0] a_q, b2_q;
  chan_mode_e    mode_q;
  logic          pol_q;
  cap_evt_t      evt;

  assign a_wr    = bus_we && (reg_sel_e'(bus_addr) == ADR_A);
  assign b_wr    = bus_we && (reg_sel_e'(bus_addr) == ADR_B);
  assign ctl_wr  = bus_we && bus_addr[1];
  assign ctl_off = ctl_wr && (chan_mode_e'(bus_wdata[2:0]) == M_OFF);
  assign rd_hit  = bus_re && !bus_addr[1];

  cc_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .pin_s(pin_s), .rise(rise), .fall(fall)
  );

  cc_capture_ctl cap_i (
    .clk(clk), .rst(rst), .mode(mode_q), .pol(pol_q),
    .rise(rise), .fall(fall), .rd_hit(rd_hit), .ctl_wr(ctl_wr),
    .evt(evt), .flag_q(cap_flag)
  );

  cc_data_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst(rst), .cnt(cnt_bus), .rd_en(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .a_wr(a_wr), .b_wr(b_wr), .ctl_wr(ctl_wr),
    .evt(evt), .a_hit(a_hit), .pin_s(pin_s), .out_q(out_q),
    .a_q(a_q), .b2_q(b2_q), .mode_q(mode_q), .pol_q(pol_q), .rdata_q(bus_rdata)
  );

  cc_compare_out #(.CW(CW)) cmp_i (
    .clk(clk), .rst(rst), .mode(mode_q), .cnt(cnt_bus), .a_q(a_q), .b2_q(b2_q),
    .a_wr(a_wr), .b_wr(b_wr), .ctl_wr(ctl_wr), .ctl_off(ctl_off),
    .a_hit(a_hit), .b_hit(b_hit), .out_q(out_q)
  );

  assign pin_out = out_q;
endmodule

// File: tb/cc_timer_channel_tb.sv
`timescale 1ns/1ps
module cc_timer_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = 16'd0;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        cap_flag;

  logic        cnt_run = 1'b0, wrap64 = 1'b0, load_req = 1'b0;
  logic [15:0] load_val = 16'd0;
  int          flag_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cc_timer_channel dut_i (
    .clk(clk), .rst(rst), .cnt_bus(cnt), .pin_in(pin_in), .pin_out(pin_out),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag)
  );

  always @(posedge clk) begin
    if (load_req)     cnt <= load_val;
    else if (cnt_run) cnt <= wrap64 ? ((cnt + 16'd1) & 16'h003F) : cnt + 16'd1;
  end

  always @(posedge clk) if (!rst && cap_flag) flag_cnt <= flag_cnt + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    @(negedge clk); load_req = 1'b1; load_val = v;
    @(negedge clk); load_req = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (cnt != v && guard < 2000);
  endtask

  // Drive an edge; return the counter value the capture must take (R5 latency).
  task automatic set_pin(input logic v, output logic [15:0] capv);
    @(negedge clk); pin_in = v;
    @(posedge clk); @(posedge clk); #1 capv = cnt;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, c1, c2, prev;
    int f0;
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(2'd0, r); check("R1 A", r, 16'h0);
    rd(2'd1, r); check("R1 B", r, 16'h0);
    rd(2'd2, r); check("R1 ctl", r, 16'h0);
    check("R1 pin_out", {15'd0, pin_out}, 16'h0);
    check("R1 cap_flag", {15'd0, cap_flag}, 16'h0);

    // R3 disabled mode: B write reaches both latches
    wr(2'd1, 16'h1234);
    rd(2'd1, r); check("R3 read B1", r, 16'h1234);
    // R2 duplicate control address: write at 3, read at 2
    wr(2'd3, 16'h0003);
    rd(2'd2, r); check("R2 ctl mirror", r, 16'h0003);
    rd(2'd3, r); check("R2 ctl dup read", r, 16'h0003);
    rd(2'd1, r); check("R3 B2 also written", r, 16'h1234);

    // R4 PWM mode keeps B2 hidden
    load_cnt(16'd77);
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0005);
    wr(2'd2, 16'h0006); wr(2'd1, 16'h0009);
    rd(2'd1, r); check("R4 PWM reads B1", r, 16'h0009);
    wr(2'd2, 16'h0003);
    rd(2'd1, r); check("R4 B2 untouched", r, 16'h0005);

    // R5 edge-capture, rising
    load_cnt(16'd100); cnt_run = 1'b1;
    wr(2'd2, 16'h0003);
    rd(2'd0, prev);
    f0 = flag_cnt;
    set_pin(1'b1, c1); settle();
    rd(2'd0, r); check("R5 A capture", r, c1);
    rd(2'd1, r); check("R5 B prev A", r, prev);
    check("R5 flag", 16'(flag_cnt - f0), 16'd1);
    // R12 status follows synced pin in input mode
    rd(2'd2, r); check("R12 status input", r, 16'h8003);
    set_pin(1'b0, c2); settle();
    rd(2'd0, r); check("R5 falling ignored", r, c1);
    check("R5 no flag on falling", 16'(flag_cnt - f0), 16'd1);
    set_pin(1'b1, c2); settle();
    rd(2'd0, r); check("R5 A second", r, c2);
    rd(2'd1, r); check("R5 B second", r, c1);

    // R6 period mode: flag from the second edge on
    wr(2'd2, 16'h0002);
    set_pin(1'b0, c1); settle();
    f0 = flag_cnt;
    set_pin(1'b1, c1); settle();
    check("R6 no flag first edge", 16'(flag_cnt - f0), 16'd0);
    set_pin(1'b0, c2); settle();
    set_pin(1'b1, c2); settle();
    check("R6 flag second edge", 16'(flag_cnt - f0), 16'd1);
    rd(2'd0, r); check("R6 A", r, c2);
    rd(2'd1, r); check("R6 B", r, c1);

    // R7 pulse width, falling leading edge (polarity bit 3 set)
    wr(2'd2, 16'h0009);
    rd(2'd1, prev);
    f0 = flag_cnt;
    set_pin(1'b0, c1); settle();
    rd(2'd1, r); check("R7 B1 hidden", r, prev);
    check("R7 no flag lead", 16'(flag_cnt - f0), 16'd0);
    set_pin(1'b1, c2); settle();
    rd(2'd0, r); check("R7 A trailing", r, c2);
    rd(2'd1, r); check("R7 B leading", r, c1);
    check("R7 flag", 16'(flag_cnt - f0), 16'd1);

    // R8 read collides with capture
    wr(2'd2, 16'h0003);
    rd(2'd0, prev);
    set_pin(1'b0, c1); settle();
    set_pin(1'b1, c1);
    rd(2'd0, r); check("R8 read returns old", r, prev);
    settle();
    rd(2'd0, r); check("R8 capture deferred", r, c1 + 16'd1);

    // Random edge captures (R5)
    for (int i = 0; i < 16; i++) begin
      load_cnt(16'($urandom));
      rd(2'd0, prev);
      set_pin(1'b0, c1); repeat (3 + ($urandom % 6)) @(posedge clk);
      set_pin(1'b1, c1); repeat (3 + ($urandom % 6)) @(posedge clk);
      rd(2'd0, r); check("R5 random A", r, c1);
      rd(2'd1, r); check("R5 random B", r, prev);
    end

    // R11 PWM with deferred duty update
    cnt_run = 1'b0; wrap64 = 1'b1;
    wr(2'd2, 16'h0000);
    load_cnt(16'd50);
    wr(2'd1, 16'd30); wr(2'd0, 16'd20);
    wr(2'd2, 16'h0006);
    cnt_run = 1'b1;
    wait_cnt(16'd22);
    check("R11 set at A", {15'd0, pin_out}, 16'h1);
    wr(2'd1, 16'd40);
    wait_cnt(16'd35); check("R11 old B2 clears", {15'd0, pin_out}, 16'h0);
    wait_cnt(16'd35); check("R11 new duty high", {15'd0, pin_out}, 16'h1);
    wait_cnt(16'd45); check("R11 new duty low", {15'd0, pin_out}, 16'h0);
    rd(2'd2, r); check("R12 status output", r, 16'h0006);
    cnt_run = 1'b0;

    // R9 double compare one-shot
    wr(2'd2, 16'h0005);
    load_cnt(16'd0);
    wr(2'd0, 16'd10); wr(2'd1, 16'd15);
    cnt_run = 1'b1;
    wait_cnt(16'd12); check("R9 A match sets", {15'd0, pin_out}, 16'h1);
    wait_cnt(16'd20); check("R9 B match clears", {15'd0, pin_out}, 16'h0);
    wait_cnt(16'd12); check("R9 A disarmed", {15'd0, pin_out}, 16'h0);
    cnt_run = 1'b0;

    // R10 single compare toggles once
    wr(2'd2, 16'h0004);
    load_cnt(16'd0);
    wr(2'd1, 16'd8);
    cnt_run = 1'b1;
    wait_cnt(16'd10); check("R10 toggle", {15'd0, pin_out}, 16'h1);
    rd(2'd2, r); check("R12 status out ff", r, 16'h8004);
    wait_cnt(16'd10); check("R10 disarmed", {15'd0, pin_out}, 16'h1);
    cnt_run = 1'b0;

    // R13 selecting disabled drives output low
    wr(2'd2, 16'h0000);
    check("R13 off clears out", {15'd0, pin_out}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule